// File: doc/BRIEF.md
# Halfword-Granule Instruction Fetch Sequencer

This block fetches a single instruction for a processor with optional 16-bit instructions. It does so in 16-bit granules. After a start it asks an extension hook to vet the program counter. The hook may reject the address with its own code, or it may name another address to fetch from. The block then checks the alignment of the address it will use and issues one translate-and-read request for the lower halfword. The low two bits of that halfword decide the width. A short instruction ends the fetch. A full-width instruction makes the block vet and request the halfword at PC+2, which is translated on its own.

The fetch ends with one result. The result is a 16-bit instruction, a 32-bit instruction, an architectural fault with a cause and an address, or an extension fault. The fault address is the halfword that failed: the original PC for the first granule and PC+2 for the second. Never the substitute address. The controller moves through idle, request-low, wait-low, request-high, wait-high and done states. It accepts a new start only while idle.

Top module: `ifetch_granule_seq`

## Requirements
- R1: After reset, `start_ready` is 1 and both `res_valid` and `mreq_valid` are 0.
- R2: A lower halfword whose bits [1:0] are not 2'b11 ends the fetch after one request. `res_kind` is 2'b00, `res_insn[15:0]` is the halfword and `res_insn[31:16]` is zero.
- R3: A lower halfword with bits [1:0] equal to 2'b11 causes exactly one more request, for the halfword at PC+2. `res_kind` is 2'b01 and `res_insn` is {upper halfword, lower halfword}.
- R4: Consider the address chosen for the first granule. If its bit 0 is set, or its bit 1 is set while `rvc_en` is 0, the result is `res_kind` 2'b10 with cause 0 and `res_addr` equal to the start PC, and no request is issued.
- R5: A hook rejection gives `res_kind` 2'b11, `res_cause` equal to `hook_code` and `res_addr` equal to the checked address. That address is PC for the first granule and PC+2 for the second. No request follows the rejection.
- R6: Each request goes to the address the hook returns. Faults from the alignment check or from the first access report the start PC even when the hook substituted another address.
- R7: A fault response to the second request gives `res_kind` 2'b10 with `res_addr` equal to PC+2. `res_cause` passes through unchanged from `mrsp_cause`, and the same holds for faults on the first request.
- R8: `res_valid` is high for exactly one cycle per fetch. The result fields hold their values until the next result.
- R9: `start_ready` is high only while idle. A start offered during a fetch is ignored and produces no extra result.
- R10: `hook_orig_pc` always carries the start PC. `hook_chk_addr` is the start PC while the first granule is handled and PC+2 while the second is handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rvc_en | input | 1 | 16-bit instruction support enabled |
| start_valid | input | 1 | Start a fetch at `start_pc` |
| start_pc | input | ADDR_W | Program counter of the instruction |
| start_ready | output | 1 | Block is idle and accepts a start |
| hook_chk_addr | output | ADDR_W | Address presented to the extension check |
| hook_orig_pc | output | ADDR_W | Untransformed PC of the current fetch |
| hook_reject | input | 1 | Extension rejects the checked address |
| hook_code | input | CAUSE_W | Extension error code |
| hook_fetch_addr | input | ADDR_W | Address to fetch instead of the checked one |
| mreq_valid | output | 1 | Translate-and-read request valid |
| mreq_addr | output | ADDR_W | Virtual address of the 2-byte execute read |
| mreq_ready | input | 1 | Request accepted |
| mrsp_valid | input | 1 | Response valid |
| mrsp_fault | input | 1 | Translation or memory fault |
| mrsp_cause | input | CAUSE_W | Fault cause code |
| mrsp_data | input | 16 | Halfword read |
| res_valid | output | 1 | One-cycle result strobe |
| res_kind | output | 2 | 00 short, 01 full, 10 fault, 11 extension fault |
| res_insn | output | 32 | Instruction bits |
| res_cause | output | CAUSE_W | Fault cause |
| res_addr | output | ADDR_W | Faulting halfword address |

## Verification
The stimulus covers short and full-width instructions at word-aligned and halfword-aligned PCs. Comparing the two shows whether the width decision and the halfword merge order are right. The same odd-halfword PC runs with `rvc_en` on and off, and a hook-forced odd address is also tried; these separate a plain alignment fault from a substitute-address fault. Faults are placed on the first and the second granule, both with and without relocation by the hook. This tells PC, PC+2 and the substitute apart as reported addresses. A start is also offered mid-fetch, while the request handshake and the response latency vary, to show that it is ignored.

// File: rtl/ifseq_pkg.sv
package ifseq_pkg;

   localparam int HALF_W = 16;
   localparam int INSN_W = 32;

   typedef enum logic [1:0] {
      KIND_SHORT = 2'b00,
      KIND_FULL  = 2'b01,
      KIND_FAULT = 2'b10,
      KIND_EXT   = 2'b11
   } fetch_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ_LO,
      ST_WAIT_LO,
      ST_REQ_HI,
      ST_WAIT_HI,
      ST_DONE
   } fetch_state_e;

   function automatic logic is_short(input logic [1:0] low_bits);
      return low_bits != 2'b11;
   endfunction

endpackage

// File: rtl/ifseq_align.sv
module ifseq_align #(
   parameter bit HAS_RVC = 1'b1
) (
   input  logic [1:0] addr_lo,
   input  logic       rvc_en,
   output logic       misaligned
);

   generate
      if (HAS_RVC) begin : g_rvc
         assign misaligned = addr_lo[0] | (addr_lo[1] & ~rvc_en);
      end else begin : g_norvc
         logic unused_rvc;
         assign unused_rvc = rvc_en;
         assign misaligned = addr_lo[0] | addr_lo[1];
      end
   endgenerate

endmodule

// File: rtl/ifseq_ctrl.sv
module ifseq_ctrl
   import ifseq_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_valid,
   input  logic [ADDR_W-1:0]  start_pc,
   output logic               start_ready,
   output logic [ADDR_W-1:0]  chk_addr,
   output logic [ADDR_W-1:0]  orig_pc,
   input  logic               hook_reject,
   input  logic [CAUSE_W-1:0] hook_code,
   input  logic [ADDR_W-1:0]  hook_fetch_addr,
   input  logic               misaligned,
   output logic               mreq_valid,
   output logic [ADDR_W-1:0]  mreq_addr,
   input  logic               mreq_ready,
   input  logic               mrsp_valid,
   input  logic               mrsp_fault,
   input  logic [CAUSE_W-1:0] mrsp_cause,
   input  logic [1:0]         mrsp_low_bits,
   output logic               lo_load,
   output logic               fin_valid,
   output fetch_kind_e        fin_kind,
   output logic [CAUSE_W-1:0] fin_cause,
   output logic [ADDR_W-1:0]  fin_addr
);

   localparam logic [ADDR_W-1:0]  HALF_STEP  = ADDR_W'(2);
   localparam logic [CAUSE_W-1:0] CAUSE_MISA = '0;

   fetch_state_e       state_q, state_d;
   logic [ADDR_W-1:0]  pc_q;
   logic [ADDR_W-1:0]  hi_pc;
   logic               on_hi;

   assign hi_pc       = pc_q + HALF_STEP;
   assign on_hi       = (state_q == ST_REQ_HI) || (state_q == ST_WAIT_HI);
   assign chk_addr    = on_hi ? hi_pc : pc_q;
   assign orig_pc     = pc_q;
   assign start_ready = (state_q == ST_IDLE);
   assign mreq_addr   = hook_fetch_addr;

   always_comb begin
      state_d    = state_q;
      mreq_valid = 1'b0;
      lo_load    = 1'b0;
      fin_valid  = 1'b0;
      fin_kind   = KIND_FAULT;
      fin_cause  = '0;
      fin_addr   = pc_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start_valid) state_d = ST_REQ_LO;
         end
         ST_REQ_LO: begin
            if (hook_reject) begin
               fin_valid = 1'b1;
               fin_kind  = KIND_EXT;
               fin_cause = hook_code;
               state_d   = ST_DONE;
            end else if (misaligned) begin
               fin_valid = 1'b1;
               fin_kind  = KIND_FAULT;
               fin_cause = CAUSE_MISA;
               state_d   = ST_DONE;
            end else begin
               mreq_valid = 1'b1;
               if (mreq_ready) state_d = ST_WAIT_LO;
            end
         end
         ST_WAIT_LO: begin
            if (mrsp_valid) begin
               if (mrsp_fault) begin
                  fin_valid = 1'b1;
                  fin_kind  = KIND_FAULT;
                  fin_cause = mrsp_cause;
                  state_d   = ST_DONE;
               end else if (is_short(mrsp_low_bits)) begin
                  fin_valid = 1'b1;
                  fin_kind  = KIND_SHORT;
                  state_d   = ST_DONE;
               end else begin
                  lo_load = 1'b1;
                  state_d = ST_REQ_HI;
               end
            end
         end
         ST_REQ_HI: begin
            if (hook_reject) begin
               fin_valid = 1'b1;
               fin_kind  = KIND_EXT;
               fin_cause = hook_code;
               fin_addr  = hi_pc;
               state_d   = ST_DONE;
            end else begin
               mreq_valid = 1'b1;
               if (mreq_ready) state_d = ST_WAIT_HI;
            end
         end
         ST_WAIT_HI: begin
            if (mrsp_valid) begin
               fin_valid = 1'b1;
               fin_addr  = hi_pc;
               state_d   = ST_DONE;
               if (mrsp_fault) begin
                  fin_kind  = KIND_FAULT;
                  fin_cause = mrsp_cause;
               end else begin
                  fin_kind  = KIND_FULL;
               end
            end
         end
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
      end else begin
         state_q <= state_d;
         if (start_ready && start_valid) pc_q <= start_pc;
      end
   end

   // after an accepted request the controller waits for its response
   assert_one_req_per_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && mreq_ready) |=> !mreq_valid);

   // the checked address steps by one halfword when the upper granule is handled
   assert_hi_check_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lo_load |=> (chk_addr == orig_pc + HALF_STEP));

endmodule

// File: rtl/ifseq_result.sv
module ifseq_result
   import ifseq_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lo_load,
   input  logic               fin_valid,
   input  fetch_kind_e        fin_kind,
   input  logic [CAUSE_W-1:0] fin_cause,
   input  logic [ADDR_W-1:0]  fin_addr,
   input  logic [HALF_W-1:0]  rsp_data,
   output logic               res_valid,
   output logic [1:0]         res_kind,
   output logic [INSN_W-1:0]  res_insn,
   output logic [CAUSE_W-1:0] res_cause,
   output logic [ADDR_W-1:0]  res_addr
);

   logic [HALF_W-1:0] lo_q;
   logic [INSN_W-1:0] insn_d;

   always_comb begin
      unique case (fin_kind)
         KIND_SHORT: insn_d = {{(INSN_W-HALF_W){1'b0}}, rsp_data};
         KIND_FULL:  insn_d = {rsp_data, lo_q};
         default:    insn_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q      <= '0;
         res_valid <= 1'b0;
         res_kind  <= KIND_SHORT;
         res_insn  <= '0;
         res_cause <= '0;
         res_addr  <= '0;
      end else begin
         res_valid <= fin_valid;
         if (lo_load) lo_q <= rsp_data;
         if (fin_valid) begin
            res_kind  <= fin_kind;
            res_insn  <= insn_d;
            res_cause <= fin_cause;
            res_addr  <= fin_addr;
         end
      end
   end

   assert_res_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   assert_short_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_kind == KIND_SHORT) |-> (res_insn[31:16] == '0 && res_insn[1:0] != 2'b11));

   assert_full_lo_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_kind == KIND_FULL) |-> (res_insn[1:0] == 2'b11));

   assert_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !fin_valid |=> $stable(res_insn) && $stable(res_addr) && $stable(res_kind));

endmodule

// File: rtl/ifetch_granule_seq.sv
module ifetch_granule_seq
   import ifseq_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CAUSE_W = 4,
   parameter bit HAS_RVC = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rvc_en,
   input  logic               start_valid,
   input  logic [ADDR_W-1:0]  start_pc,
   output logic               start_ready,
   output logic [ADDR_W-1:0]  hook_chk_addr,
   output logic [ADDR_W-1:0]  hook_orig_pc,
   input  logic               hook_reject,
   input  logic [CAUSE_W-1:0] hook_code,
   input  logic [ADDR_W-1:0]  hook_fetch_addr,
   output logic               mreq_valid,
   output logic [ADDR_W-1:0]  mreq_addr,
   input  logic               mreq_ready,
   input  logic               mrsp_valid,
   input  logic               mrsp_fault,
   input  logic [CAUSE_W-1:0] mrsp_cause,
   input  logic [15:0]        mrsp_data,
   output logic               res_valid,
   output logic [1:0]         res_kind,
   output logic [31:0]        res_insn,
   output logic [CAUSE_W-1:0] res_cause,
   output logic [ADDR_W-1:0]  res_addr
);

   generate
      if (ADDR_W < 8) begin : g_bad_addr_w
         $error("ifetch_granule_seq: ADDR_W must be at least 8");
      end
      if (CAUSE_W < 1) begin : g_bad_cause_w
         $error("ifetch_granule_seq: CAUSE_W must be at least 1");
      end
   endgenerate

   logic               misaligned;
   logic               lo_load;
   logic               fin_valid;
   fetch_kind_e        fin_kind;
   logic [CAUSE_W-1:0] fin_cause;
   logic [ADDR_W-1:0]  fin_addr;

   ifseq_align #(.HAS_RVC(HAS_RVC)) u_align (
      .addr_lo    (hook_fetch_addr[1:0]),
      .rvc_en     (rvc_en),
      .misaligned (misaligned)
   );

   ifseq_ctrl #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .start_valid     (start_valid),
      .start_pc        (start_pc),
      .start_ready     (start_ready),
      .chk_addr        (hook_chk_addr),
      .orig_pc         (hook_orig_pc),
      .hook_reject     (hook_reject),
      .hook_code       (hook_code),
      .hook_fetch_addr (hook_fetch_addr),
      .misaligned      (misaligned),
      .mreq_valid      (mreq_valid),
      .mreq_addr       (mreq_addr),
      .mreq_ready      (mreq_ready),
      .mrsp_valid      (mrsp_valid),
      .mrsp_fault      (mrsp_fault),
      .mrsp_cause      (mrsp_cause),
      .mrsp_low_bits   (mrsp_data[1:0]),
      .lo_load         (lo_load),
      .fin_valid       (fin_valid),
      .fin_kind        (fin_kind),
      .fin_cause       (fin_cause),
      .fin_addr        (fin_addr)
   );

   ifseq_result #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)) u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .lo_load   (lo_load),
      .fin_valid (fin_valid),
      .fin_kind  (fin_kind),
      .fin_cause (fin_cause),
      .fin_addr  (fin_addr),
      .rsp_data  (mrsp_data),
      .res_valid (res_valid),
      .res_kind  (res_kind),
      .res_insn  (res_insn),
      .res_cause (res_cause),
      .res_addr  (res_addr)
   );

   assert_idle_after_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> start_ready);

   assert_no_req_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_ready |-> !mreq_valid);

   assert_misalign_blocks_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (misaligned && !hook_reject && hook_chk_addr == hook_orig_pc && !start_ready)
         |-> !mreq_valid);

endmodule

// File: tb/ifetch_granule_seq_tb.sv
module ifetch_granule_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        rvc_en;
   logic        start_valid;
   logic [31:0] start_pc;
   logic        start_ready;
   logic [31:0] hook_chk_addr, hook_orig_pc, hook_fetch_addr;
   logic        hook_reject;
   logic [3:0]  hook_code;
   logic        mreq_valid, mreq_ready;
   logic [31:0] mreq_addr;
   logic        mrsp_valid, mrsp_fault;
   logic [3:0]  mrsp_cause;
   logic [15:0] mrsp_data;
   logic        res_valid;
   logic [1:0]  res_kind;
   logic [31:0] res_insn;
   logic [3:0]  res_cause;
   logic [31:0] res_addr;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   ifetch_granule_seq u_dut (.*);

   // environment: extension hook, pure function of the checked address
   function automatic logic [31:0] hook_map(input logic [31:0] a);
      if (a[20]) return a | 32'h1;
      if (a[21]) return a ^ 32'h0040_0000;
      return a;
   endfunction
   function automatic logic hook_rej(input logic [31:0] a);
      return a[7:0] == 8'hC6;
   endfunction
   assign hook_fetch_addr = hook_map(hook_chk_addr);
   assign hook_reject     = hook_rej(hook_chk_addr);
   assign hook_code       = 4'h9;

   // environment: memory contents and faults
   function automatic logic [15:0] mem_data(input logic [31:0] a);
      return {a[15:2] ^ 14'h02A5, a[6] ? 2'b11 : 2'b01};
   endfunction
   function automatic logic [3:0] mem_cause(input logic [31:0] a);
      if (a[11:8] == 4'hF) return 4'd5;
      if (a[11:8] == 4'hE) return 4'd13;
      return 4'd0;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // reference model state
   logic [31:0] exp_req[$];
   bit          exp_pending = 0;
   logic [1:0]  exp_kind;
   logic [31:0] exp_insn, exp_addr, cur_pc;
   logic [3:0]  exp_cause;

   task automatic model(input logic [31:0] pc, input logic rvc);
      logic [31:0] u0, u1, hi;
      logic [15:0] d0, d1;
      exp_insn = 0; exp_cause = 0; exp_addr = pc;
      hi = pc + 32'd2;
      u0 = hook_map(pc);
      if (hook_rej(pc)) begin exp_kind = 2'b11; exp_cause = 4'h9; return; end
      if (u0[0] || (u0[1] && !rvc)) begin exp_kind = 2'b10; return; end
      exp_req.push_back(u0);
      if (mem_cause(u0) != 0) begin exp_kind = 2'b10; exp_cause = mem_cause(u0); return; end
      d0 = mem_data(u0);
      if (d0[1:0] != 2'b11) begin exp_kind = 2'b00; exp_insn = {16'h0, d0}; return; end
      exp_addr = hi;
      if (hook_rej(hi)) begin exp_kind = 2'b11; exp_cause = 4'h9; return; end
      u1 = hook_map(hi);
      exp_req.push_back(u1);
      if (mem_cause(u1) != 0) begin exp_kind = 2'b10; exp_cause = mem_cause(u1); return; end
      d1 = mem_data(u1);
      exp_kind = 2'b01; exp_insn = {d1, d0}; exp_addr = pc;
   endtask

   // per-clock responder and comparison, all at the falling edge
   logic [31:0] pend_addr[$];
   int          pend_dly[$];
   logic [7:0]  lfsr = 8'hB5;
   bit          prev_res = 0;

   always @(negedge clk) begin
      logic [31:0] a;
      if (!rst_n) begin
         mrsp_valid = 1'b0; mreq_ready = 1'b0; prev_res = 0;
      end else begin
         mrsp_valid = 1'b0;
         if (pend_addr.size() > 0) begin
            if (pend_dly[0] == 0) begin
               a = pend_addr.pop_front();
               void'(pend_dly.pop_front());
               mrsp_valid = 1'b1;
               mrsp_cause = mem_cause(a);
               mrsp_fault = (mem_cause(a) != 0);
               mrsp_data  = mem_data(a);
            end else begin
               pend_dly[0] = pend_dly[0] - 1;
            end
         end
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         mreq_ready = lfsr[0] | lfsr[3];
         if (mreq_valid) begin
            check(hook_orig_pc == cur_pc, "R10", "hook original PC", hook_orig_pc, cur_pc);
         end
         if (mreq_valid && mreq_ready) begin
            if (exp_req.size() == 0) begin
               check(0, "R3", "unexpected request", mreq_addr, 0);
            end else begin
               a = exp_req.pop_front();
               check(mreq_addr == a, "R6", "request address", mreq_addr, a);
            end
            pend_addr.push_back(mreq_addr);
            pend_dly.push_back(lfsr[2:1] == 2'b11 ? 0 : int'(lfsr[2:1]));
         end
         if (mreq_valid && start_ready) check(0, "R9", "request while idle", 1, 0);
         if (prev_res) check(!res_valid, "R8", "strobe longer than one cycle", res_valid, 0);
         if (res_valid) begin
            if (!exp_pending) begin
               check(0, "R9", "extra result", res_addr, 0);
            end else begin
               check(res_kind == exp_kind, "R2 R3 R4 R5", "kind", res_kind, exp_kind);
               check(res_insn == exp_insn, "R2 R3", "insn", res_insn, exp_insn);
               if (exp_kind[1]) begin
                  check(res_cause == exp_cause, "R7", "cause", res_cause, exp_cause);
                  check(res_addr == exp_addr, "R5 R6 R7", "fault addr", res_addr, exp_addr);
               end
               check(exp_req.size() == 0, "R4", "requests left", exp_req.size(), 0);
               exp_pending = 0;
            end
         end
         prev_res = res_valid;
      end
   end

   task automatic do_fetch(input logic [31:0] pc, input logic rvc, input bit inject);
      int t;
      while (!start_ready) @(negedge clk);
      rvc_en = rvc;
      cur_pc = pc;
      model(pc, rvc);
      exp_pending = 1;
      start_valid = 1'b1;
      start_pc    = pc;
      @(negedge clk);
      start_valid = 1'b0;
      if (inject) begin
         // R9: a start during the fetch must be ignored
         check(!start_ready, "R9", "ready while busy", start_ready, 0);
         start_valid = 1'b1;
         start_pc    = 32'h0000_0004;
         @(negedge clk);
         start_valid = 1'b0;
      end
      t = 0;
      while (exp_pending && t < 300) begin @(negedge clk); t++; end
      if (exp_pending) begin
         check(0, "R8", "result timeout", 0, 1);
         exp_pending = 0;
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      check(0, "R8", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] held_insn, held_addr;
      logic [1:0]  held_kind;
      rst_n = 1'b0; rvc_en = 1'b1; start_valid = 1'b0; start_pc = '0;
      mrsp_valid = 1'b0; mrsp_fault = 1'b0; mrsp_cause = '0; mrsp_data = '0;
      mreq_ready = 1'b0; cur_pc = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(start_ready == 1'b1, "R1", "start_ready", start_ready, 1);
      check(res_valid == 1'b0, "R1", "res_valid", res_valid, 0);
      check(mreq_valid == 1'b0, "R1", "mreq_valid", mreq_valid, 0);

      do_fetch(32'h0000_0040, 1'b1, 0);   // R3 full width, aligned
      do_fetch(32'h0000_0004, 1'b1, 0);   // R2 short
      do_fetch(32'h0000_0042, 1'b1, 0);   // R3 full at odd halfword
      do_fetch(32'h0000_0042, 1'b0, 0);   // R4 bit 1 without short support
      do_fetch(32'h0000_0041, 1'b1, 0);   // R4 bit 0
      do_fetch(32'h0000_01C6, 1'b1, 0);   // R5 first granule rejected
      do_fetch(32'h0000_00C4, 1'b1, 0);   // R5 second granule rejected, PC+2
      do_fetch(32'h0010_0040, 1'b1, 0);   // R6 substitute misaligned, PC reported
      do_fetch(32'h0020_0040, 1'b1, 0);   // R6 relocated full fetch
      do_fetch(32'h0000_0F40, 1'b1, 0);   // R7 first granule fault
      do_fetch(32'h0020_0E40, 1'b1, 0);   // R6 relocated fault reports PC
      do_fetch(32'h0000_0DFE, 1'b1, 0);   // R7 second granule fault at PC+2
      do_fetch(32'h0000_0140, 1'b1, 1);   // R9 start offered while busy

      // R8: fields hold after the strobe
      held_insn = res_insn; held_addr = res_addr; held_kind = res_kind;
      repeat (5) @(negedge clk);
      check(res_insn == held_insn, "R8", "insn held", res_insn, held_insn);
      check(res_addr == held_addr && res_kind == held_kind, "R8", "addr/kind held",
            res_addr, held_addr);
      check(res_valid == 1'b0, "R9", "no result from ignored start", res_valid, 0);

      for (int i = 0; i < 24; i++) begin
         do_fetch(32'h0000_1000 + 32'(i * 6), i[0], 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule